// File: doc/BRIEF.md
# MAC Interrupt Cause Register

This block holds the pending interrupt causes of a network MAC and presents them to software through a small 32-bit register port. The transmit and receive descriptor engines each signal events as single-cycle pulses: frame sent, transmit failure, frame received, receive failure, and receive stalled for lack of a free buffer. Each pulse latches a sticky cause bit. Software reads the cause register to learn what happened. It then writes the value back, and every 1 in the written value clears the matching bit.

Because clearing is write-one-to-clear, software can write back exactly the value it read. A cause that arrives between the read and the write-back is then not lost. If a cause pulse lands in the same cycle as the clear of that bit, the pulse wins. A companion enable register selects which causes drive the single active-high interrupt line. Causes that are not enabled still latch and can still be read.

Top module: `mac_irq_cause`

## Requirements
- R1: After reset, the cause bits, the enable bits, the interrupt output and the acknowledge are all zero.
- R2: Each cause input latches its own bit at the next clock edge, and the bit stays set with no further pulses. The bit positions are: bit 0 transmit done (`ev_tx_done`), bit 1 transmit error (`ev_tx_err`), bit 2 receive done (`ev_rx_done`), bit 3 receive error (`ev_rx_err`) and bit 4 out of receive buffers (`ev_rx_nobuf`).
- R3: A write to byte offset 0x04 clears every cause bit whose write-data bit is 1. Cause bits whose write-data bit is 0 are left unchanged.
- R4: When a cause pulse and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R5: The enable register sits at byte offset 0x08. Its bits [4:0] are written and read back as given, and its bits [31:5] read as zero.
- R6: `irq` is high exactly while at least one cause bit is set whose enable bit is also set. A cause that is not enabled still latches and reads back as 1.
- R7: Bits [31:5] of the cause register read as zero. Writing ones to those bits has no effect on the bits [4:0].
- R8: Every request is acknowledged in the cycle after it is sampled, with one acknowledge pulse per request. Read data is valid while the acknowledge is high and shows the register as it was when the request was sampled. Read data is zero on writes.
- R9: A read of any other offset returns zero. A write to any other offset changes neither the cause register nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access acknowledge |
| ev_tx_done | input | 1 | Pulse: frame transmitted |
| ev_tx_err | input | 1 | Pulse: transmit error |
| ev_rx_done | input | 1 | Pulse: frame received |
| ev_rx_err | input | 1 | Pulse: receive error |
| ev_rx_nobuf | input | 1 | Pulse: no receive buffer free |
| irq | output | 1 | Interrupt, high while an enabled cause is pending |

## Verification
A table of steps drives pulse patterns together with clear patterns in the same cycle. Some steps set and clear disjoint bits, some overlap on one bit, one clears every bit at once, and some use alternating masks. Together these separate a correct write-one-to-clear from a plain write, from a write-zero-to-clear and from a clear that overrides a pulse. Directed tests then run with the enable register at all-zero and at single bits, to show that latching does not depend on the enable. They also write ones into the unused upper bits and access an unmapped offset.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int NCAUSE = 5;

  // Bit positions of the cause sources (decoded by software)
  localparam int BIT_TX_DONE  = 0;
  localparam int BIT_TX_ERR   = 1;
  localparam int BIT_RX_DONE  = 2;
  localparam int BIT_RX_ERR   = 3;
  localparam int BIT_RX_NOBUF = 4;

  typedef logic [NCAUSE-1:0] cause_t;

  // Next state of the sticky bits: a new pulse beats a clear
  function automatic cause_t cause_next(cause_t cur, cause_t set, cause_t clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_any(cause_t cause, cause_t en);
    return |(cause & en);
  endfunction
endpackage

// File: rtl/mic_addr_dec.sv
module mic_addr_dec #(
  parameter int ADDR_W    = 8,
  parameter int CAUSE_OFS = 4,
  parameter int MASK_OFS  = 8
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              cause_wr,
  output logic              mask_wr,
  output logic              cause_rd,
  output logic              mask_rd
);
  logic hit_cause, hit_mask;

  assign hit_cause = (addr == ADDR_W'(CAUSE_OFS));
  assign hit_mask  = (addr == ADDR_W'(MASK_OFS));

  assign cause_wr = req &  we & hit_cause;
  assign mask_wr  = req &  we & hit_mask;
  assign cause_rd = req & ~we & hit_cause;
  assign mask_rd  = req & ~we & hit_mask;
endmodule

// File: rtl/mic_cause_bank.sv
module mic_cause_bank
  import mic_pkg::*;
#(
  parameter int N = NCAUSE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] cause_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[i] <= 1'b0;
      else        cause_q[i] <= set_vec[i] | (cause_q[i] & ~clr_vec[i]);
    end
  end
endmodule

// File: rtl/mic_rd_port.sv
module mic_rd_port #(
  parameter int DATA_W = 32,
  parameter int N      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              cause_rd,
  input  logic              mask_rd,
  input  logic [N-1:0]      cause_q,
  input  logic [N-1:0]      mask_q,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  logic [N-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    if (cause_rd) sel_val = cause_q;
    else if (mask_rd) sel_val = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      rdata <= DATA_W'(sel_val);
    end
  end
endmodule

// File: rtl/mac_irq_cause.sv
module mac_irq_cause
  import mic_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CAUSE_OFS = 4,
  parameter int MASK_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              ev_tx_done,
  input  logic              ev_tx_err,
  input  logic              ev_rx_done,
  input  logic              ev_rx_err,
  input  logic              ev_rx_nobuf,
  output logic              irq
);
  localparam int N = NCAUSE;

  logic   cause_wr, mask_wr, cause_rd, mask_rd;
  cause_t set_vec, clr_vec, cause_q, mask_q;
  logic   mask_we;
  logic   unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N];

  always_comb begin
    set_vec               = '0;
    set_vec[BIT_TX_DONE]  = ev_tx_done;
    set_vec[BIT_TX_ERR]   = ev_tx_err;
    set_vec[BIT_RX_DONE]  = ev_rx_done;
    set_vec[BIT_RX_ERR]   = ev_rx_err;
    set_vec[BIT_RX_NOBUF] = ev_rx_nobuf;
  end

  mic_addr_dec #(
    .ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr),
    .cause_wr(cause_wr), .mask_wr(mask_wr),
    .cause_rd(cause_rd), .mask_rd(mask_rd)
  );

  assign clr_vec = cause_wr ? bus_wdata[N-1:0] : '0;
  assign mask_we = mask_wr;

  mic_cause_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec), .cause_q(cause_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= bus_wdata[N-1:0];
  end

  mic_rd_port #(.DATA_W(DATA_W), .N(N)) u_rd (
    .clk(clk), .rst_n(rst_n), .req(bus_req),
    .cause_rd(cause_rd), .mask_rd(mask_rd),
    .cause_q(cause_q), .mask_q(mask_q),
    .rdata(bus_rdata), .ack(bus_ack)
  );

  assign irq = irq_any(cause_q, mask_q);
endmodule

// File: rtl/mac_irq_cause_chk.sv
module mac_irq_cause_chk #(
  parameter int DATA_W = 32,
  parameter int N      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [N-1:0]      cause_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      set_vec,
  input logic [N-1:0]      clr_vec,
  input logic              mask_we
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (cause_q == '0 && mask_q == '0 && !bus_ack));

  assert_pulse_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0));

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & clr_vec)) |=>
      ((cause_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|set_vec) || mask_we));

  assert_irq_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past((|clr_vec) || mask_we));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (bus_rdata[DATA_W-1:N] == '0));

  assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);

  assert_no_spurious_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);
endmodule

bind mac_irq_cause mac_irq_cause_chk #(.DATA_W(DATA_W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_rdata(bus_rdata), .irq(irq), .cause_q(cause_q), .mask_q(mask_q),
  .set_vec(set_vec), .clr_vec(clr_vec), .mask_we(mask_we)
);

// File: tb/tb_mac_irq_cause.sv
module tb_mac_irq_cause;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CAUSE = 8'h04;
  localparam logic [7:0] A_MASK  = 8'h08;
  localparam logic [7:0] A_OTHER = 8'h0C;

  // {set[4:0], clr[4:0], expected cause[4:0]}
  localparam int NVEC = 8;
  localparam logic [14:0] VEC [NVEC] = '{
    {5'b00001, 5'b00000, 5'b00001},
    {5'b00110, 5'b00000, 5'b00111},
    {5'b00000, 5'b00010, 5'b00101},
    {5'b11000, 5'b00001, 5'b11100},
    {5'b00100, 5'b00100, 5'b11100},
    {5'b00000, 5'b11111, 5'b00000},
    {5'b10101, 5'b01010, 5'b10101},
    {5'b01010, 5'b10101, 5'b01010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, irq;
  logic [4:0]  ev = '0;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_cause dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .ev_tx_done(ev[0]), .ev_tx_err(ev[1]),
    .ev_rx_done(ev[2]), .ev_rx_err(ev[3]), .ev_rx_nobuf(ev[4]), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One access, with optional cause pulses in the same cycle; ack checked (R8)
  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        input logic [4:0] pulses, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; ev = pulses;
    @(negedge clk);
    bus_req = 1'b0; ev = '0;
    check("R8 ack", {31'b0, bus_ack}, 32'd1);
    rd = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] p);
    @(negedge clk);
    ev = p;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", {31'b0, bus_ack}, 32'd0);
    check("R1 irq", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, A_CAUSE, 0, 5'b0, rd); check("R1 cause", rd, 32'h0);
    access(1'b0, A_MASK, 0, 5'b0, rd);  check("R1 mask", rd, 32'h0);
    @(negedge clk);
    check("R8 idle no ack", {31'b0, bus_ack}, 32'd0);

    // enable all, walk table (R2 R3 R4 R6)
    access(1'b1, A_MASK, 32'h1F, 5'b0, rd);
    check("R8 write rdata zero", rd, 32'h0);
    for (int i = 0; i < NVEC; i++) begin
      access(1'b1, A_CAUSE, {27'b0, VEC[i][9:5]}, VEC[i][14:10], rd);
      access(1'b0, A_CAUSE, 0, 5'b0, rd);
      check("R2/R3/R4 table cause", rd, {27'b0, VEC[i][4:0]});
      check("R6 table irq", {31'b0, irq}, {31'b0, |VEC[i][4:0]});
    end

    // R5 enable register readback
    access(1'b1, A_MASK, 32'hFFFF_FFE5, 5'b0, rd);
    access(1'b0, A_MASK, 0, 5'b0, rd); check("R5 mask readback", rd, 32'h05);

    // R6 disabled causes latch but do not raise irq
    access(1'b1, A_CAUSE, 32'h1F, 5'b0, rd);
    access(1'b1, A_MASK, 32'h0, 5'b0, rd);
    pulse(5'b01000);
    check("R6 masked irq low", {31'b0, irq}, 32'd0);
    access(1'b0, A_CAUSE, 0, 5'b0, rd); check("R6 masked cause set", rd, 32'h08);
    access(1'b1, A_MASK, 32'h10, 5'b0, rd);
    check("R6 other bit enabled irq low", {31'b0, irq}, 32'd0);
    access(1'b1, A_MASK, 32'h08, 5'b0, rd);
    check("R6 enabled irq high", {31'b0, irq}, 32'd1);

    // R2 sticky after pulse stops
    pulse(5'b10000);
    repeat (4) @(negedge clk);
    access(1'b0, A_CAUSE, 0, 5'b0, rd); check("R2 sticky", rd, 32'h18);

    // R7 upper bits ignore writes, read zero
    pulse(5'b11111);
    access(1'b1, A_CAUSE, 32'hFFFF_FFE0, 5'b0, rd);
    access(1'b0, A_CAUSE, 0, 5'b0, rd); check("R7 upper write ignored", rd, 32'h1F);

    // R9 unmapped offset
    access(1'b1, A_OTHER, 32'hFFFF_FFFF, 5'b0, rd);
    access(1'b0, A_OTHER, 0, 5'b0, rd); check("R9 unmapped read", rd, 32'h0);
    access(1'b0, A_CAUSE, 0, 5'b0, rd); check("R9 cause untouched", rd, 32'h1F);
    access(1'b0, A_MASK, 0, 5'b0, rd);  check("R9 mask untouched", rd, 32'h08);

    // R3 clear all drops irq
    access(1'b1, A_CAUSE, 32'h1F, 5'b0, rd);
    check("R3 irq after clear", {31'b0, irq}, 32'd0);
    access(1'b0, A_CAUSE, 0, 5'b0, rd); check("R3 all clear", rd, 32'h0);

    // R8 read shows value before a pulse arriving with it
    access(1'b0, A_CAUSE, 0, 5'b00001, rd); check("R8 read pre-pulse", rd, 32'h0);
    access(1'b0, A_CAUSE, 0, 5'b0, rd);     check("R2 tx_done bit0", rd, 32'h1);

    done = 1;
    summary();
  end
endmodule